// File: doc/BRIEF.md
# Triplex Channel Cycle Synchronizer

Three redundant computers must begin each task cycle together. This block is the per-channel alignment logic. The channel drives two discrete handshake lines to its peers and samples one line from each peer. In the system the lines are cross-wired in a rotating pattern: each channel watches the first line of one neighbour and the second line of the other. After reset the channel waits, with no time limit, until both peers are present. It then starts its first task period.

From then on, every task period ends with a handshake window of bounded length. A handshake in which both peers answer leads to a short guard interval with the lines still high. The next task period then uses the success duration. A window that expires leads to a safe interval with the lines low. The next task period then uses a longer or shorter failure duration, chosen so that the overall cycle stays near its nominal length.

A small saturating miss counter is kept for each peer. A peer is flagged faulty after more than three consecutive missed handshakes. A streak counter of successful handshakes tells a recovering channel when it may take part in voting again.

Top module: `tri_sync_chan`

## Requirements
- R1: Each peer input passes through two flip-flops before the handshake logic uses it. Both handshake outputs always carry the same level.
- R2: After reset both handshake outputs are high and no task starts. The channel stays in this state for as long as it takes until both synchronized peer inputs are high. It then pulses `task_start_o` with `task_ok_o`=1 and `task_len_o`=OK_TICKS.
- R3: During a task period both handshake outputs are low and `task_busy_o` is high. The period lasts the selected duration in cycles, and then the handshake window opens with both outputs high.
- R4: When both synchronized peers are high in any cycle of the window, the outputs stay high for GUARD_TICKS more cycles. The next task then starts with `task_ok_o`=1 and length OK_TICKS. Seeing both peers in the last window cycle counts as success, not expiry. With the peers already high, consecutive starts are L+1+GUARD_TICKS cycles apart, where L is the previous task length.
- R5: A window lasts at most HS_TICKS cycles. If it expires, the outputs go low for SAFE_TICKS cycles, and then the next task starts with `task_ok_o`=0 and length FAIL_TICKS. Consecutive starts are then L+HS_TICKS+SAFE_TICKS cycles apart.
- R6: On expiry, the miss counter of each peer not seen high during the window increments (saturating). The counter of a peer that was seen is cleared, and a success clears both. `peer_fault_o[i]` is high while peer i's counter exceeds FAIL_LIMIT (3), that is, from the fourth consecutive miss. Bit 0 is the peer on `peer0_i`.
- R7: A failed handshake does not stop the next one. The following period ends in a full window again, and a success there is accepted.
- R8: `rejoin_ok_o` rises on the REJOIN_CNT-th (3rd) consecutive successful handshake and drops on any failure. The startup rendezvous does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| peer0_i | input | 1 | Handshake line sampled from first peer |
| peer1_i | input | 1 | Handshake line sampled from second peer |
| sync_x_o | output | 1 | First handshake output |
| sync_y_o | output | 1 | Second handshake output |
| task_start_o | output | 1 | One-cycle pulse at the start of each task period |
| task_busy_o | output | 1 | High while the task period runs |
| task_ok_o | output | 1 | Result of the handshake that led to the current task |
| task_len_o | output | TMR_W | Selected task duration in cycles |
| peer_fault_o | output | 2 | Per-peer fault flags |
| rejoin_ok_o | output | 1 | Channel qualified to rejoin |

## Verification
Handshake success and window expiry can fall in the same cycle: a peer whose synchronized level first shows high in the last window cycle. The bench raises a peer line at every offset from the start of the window to beyond its end. For each offset it works out, from the two-flop delay, whether the level lands inside the window. It then judges `task_ok_o` and `task_len_o` at the next task start. In the same way, a miss-counter increment and a clear can fall in one window. With one peer present and the other absent, the bench checks that the faults of the two peers part ways.

// File: rtl/tri_sync_pkg.sv
package tri_sync_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_TASK,
    ST_HS,
    ST_GUARD,
    ST_SAFE
  } phase_e;
endpackage

// File: rtl/tri_sync_cdc.sv
module tri_sync_cdc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/tri_sync_peer_mon.sv
module tri_sync_peer_mon #(
  parameter int unsigned FAIL_LIMIT = 3,
  localparam int unsigned FCNT_W = $clog2(FAIL_LIMIT + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_i,
  input  logic fail_i,
  input  logic seen_i,
  output logic fault_o
);
  localparam logic [FCNT_W-1:0] CNT_MAX = '1;
  logic [FCNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (pass_i)               cnt_q <= '0;
    else if (fail_i && seen_i)     cnt_q <= '0;
    else if (fail_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign fault_o = (cnt_q > FCNT_W'(FAIL_LIMIT));

  // R6
  fault_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(fail_i) && !$past(seen_i));

  // R6
  fault_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |=> !fault_o);
endmodule

// File: rtl/tri_sync_chan.sv
module tri_sync_chan
  import tri_sync_pkg::*;
#(
  parameter int unsigned HS_TICKS    = 25000,
  parameter int unsigned SAFE_TICKS  = 5000,
  parameter int unsigned GUARD_TICKS = 5000,
  parameter int unsigned OK_TICKS    = 470000,
  parameter int unsigned FAIL_TICKS  = 465000,
  parameter int unsigned FAIL_LIMIT  = 3,
  parameter int unsigned REJOIN_CNT  = 3,
  localparam int unsigned MAX_A = (OK_TICKS > FAIL_TICKS) ? OK_TICKS : FAIL_TICKS,
  localparam int unsigned MAX_B = (HS_TICKS > SAFE_TICKS) ? HS_TICKS : SAFE_TICKS,
  localparam int unsigned MAX_C = (MAX_B > GUARD_TICKS) ? MAX_B : GUARD_TICKS,
  localparam int unsigned MAX_T = (MAX_A > MAX_C) ? MAX_A : MAX_C,
  localparam int unsigned TMR_W = $clog2(MAX_T + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             peer0_i,
  input  logic             peer1_i,
  output logic             sync_x_o,
  output logic             sync_y_o,
  output logic             task_start_o,
  output logic             task_busy_o,
  output logic             task_ok_o,
  output logic [TMR_W-1:0] task_len_o,
  output logic [1:0]       peer_fault_o,
  output logic             rejoin_ok_o
);
  localparam int unsigned NPEER = 2;
  localparam int unsigned STK_W = $clog2(REJOIN_CNT + 1);

  phase_e            state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              start_q, start_d;
  logic              ok_q, ok_d;
  logic [STK_W-1:0]  streak_q;
  logic [NPEER-1:0]  peer_raw, peer_s, seen_q, seen_now;
  logic              both_s, tmr_zero, pass_ev, fail_ev;

  assign peer_raw = {peer1_i, peer0_i};

  for (genvar i = 0; i < NPEER; i++) begin : g_peer
    tri_sync_cdc u_cdc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (peer_raw[i]),
      .q_o   (peer_s[i])
    );

    tri_sync_peer_mon #(.FAIL_LIMIT(FAIL_LIMIT)) u_mon (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pass_i (pass_ev),
      .fail_i (fail_ev),
      .seen_i (seen_now[i]),
      .fault_o(peer_fault_o[i])
    );
  end

  assign both_s   = &peer_s;
  assign tmr_zero = (tmr_q == '0);
  assign pass_ev  = (state_q == ST_HS) && both_s;
  assign fail_ev  = (state_q == ST_HS) && tmr_zero && !both_s;
  assign seen_now = seen_q | peer_s;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_zero ? tmr_q : tmr_q - 1'b1;
    start_d = 1'b0;
    ok_d    = ok_q;
    unique case (state_q)
      ST_BOOT: if (both_s) begin
        state_d = ST_TASK;
        tmr_d   = TMR_W'(OK_TICKS - 1);
        start_d = 1'b1;
        ok_d    = 1'b1;
      end
      ST_TASK: if (tmr_zero) begin
        state_d = ST_HS;
        tmr_d   = TMR_W'(HS_TICKS - 1);
      end
      ST_HS: begin
        // success wins over expiry in the last window cycle
        if (both_s) begin
          state_d = ST_GUARD;
          tmr_d   = TMR_W'(GUARD_TICKS - 1);
        end else if (tmr_zero) begin
          state_d = ST_SAFE;
          tmr_d   = TMR_W'(SAFE_TICKS - 1);
        end
      end
      ST_GUARD: if (tmr_zero) begin
        state_d = ST_TASK;
        tmr_d   = TMR_W'(OK_TICKS - 1);
        start_d = 1'b1;
        ok_d    = 1'b1;
      end
      ST_SAFE: if (tmr_zero) begin
        state_d = ST_TASK;
        tmr_d   = TMR_W'(FAIL_TICKS - 1);
        start_d = 1'b1;
        ok_d    = 1'b0;
      end
      default: state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      tmr_q   <= '0;
      start_q <= 1'b0;
      ok_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      start_q <= start_d;
      ok_q    <= ok_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                seen_q <= '0;
    else if (state_q == ST_TASK)                seen_q <= '0;
    else if (state_q == ST_HS)                  seen_q <= seen_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       streak_q <= '0;
    else if (fail_ev)                                  streak_q <= '0;
    else if (pass_ev && streak_q != STK_W'(REJOIN_CNT)) streak_q <= streak_q + 1'b1;
  end

  assign sync_x_o     = (state_q == ST_BOOT) || (state_q == ST_HS) || (state_q == ST_GUARD);
  assign sync_y_o     = sync_x_o;
  assign task_start_o = start_q;
  assign task_busy_o  = (state_q == ST_TASK);
  assign task_ok_o    = ok_q;
  assign task_len_o   = ok_q ? TMR_W'(OK_TICKS) : TMR_W'(FAIL_TICKS);
  assign rejoin_ok_o  = (streak_q >= STK_W'(REJOIN_CNT));

  // R2
  boot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOOT && !both_s) |=> (state_q == ST_BOOT) && !task_start_o);

  // R3
  task_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_start_o |-> task_busy_o && !sync_x_o && !sync_y_o);

  // R4
  guard_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GUARD && tmr_zero) |=> task_start_o && task_ok_o);

  // R5
  fail_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_ev |=> !sync_x_o && !task_busy_o);

  // R8
  rejoin_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rejoin_ok_o) |-> $past(pass_ev));

  // R8
  rejoin_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_ev |=> !rejoin_ok_o);
endmodule

// File: tb/sim_tri_sync_chan.sv
module sim_tri_sync_chan;
  localparam int unsigned HS = 8, SF = 3, GD = 2, OKL = 20, FL = 17;
  localparam int unsigned TW = $clog2(20 + 1);

  logic clk = 1'b0, rst_n = 1'b0, p0 = 1'b0, p1 = 1'b0;
  logic x, y, st, busy, ok, rj;
  logic [TW-1:0] len;
  logic [1:0] flt;
  int checks = 0, fails = 0;
  int cyc = 0, last_start = 0, gap = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_sync_chan #(.HS_TICKS(HS), .SAFE_TICKS(SF), .GUARD_TICKS(GD),
                  .OK_TICKS(OKL), .FAIL_TICKS(FL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .peer0_i(p0), .peer1_i(p1),
    .sync_x_o(x), .sync_y_o(y), .task_start_o(st), .task_busy_o(busy),
    .task_ok_o(ok), .task_len_o(len), .peer_fault_o(flt), .rejoin_ok_o(rj));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start(input string req);
    bit seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (st) seen = 1;
    end
    chk({req, " start seen"}, int'(seen), 1);
    gap = cyc - last_start;
    last_start = cyc;
  endtask

  task automatic success_step(input int prev_len, input int exp_rj, input string req);
    wait_start(req);
    chk({req, " gap ok"}, gap, prev_len + 1 + GD);
    chk({req, " ok"}, int'(ok), 1);
    chk({req, " len"}, int'(len), OKL);
    chk("R8 rejoin", int'(rj), exp_rj);
  endtask

  initial begin
    int boot_starts = 0;
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 x reset", int'(x), 1);
    chk("R1 y equals x", int'(y), 1);
    chk("R2 start reset", int'(st), 0);
    chk("R3 busy reset", int'(busy), 0);
    chk("R6 fault reset", int'(flt), 0);
    chk("R8 rejoin reset", int'(rj), 0);
    // R2 boot waits indefinitely; one peer alone is not enough
    p0 = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (st) boot_starts++;
    end
    chk("R2 no start while waiting", boot_starts, 0);
    chk("R2 x held high", int'(x), 1);
    p1 = 1'b1;
    wait_start("R2");
    chk("R2 boot ok", int'(ok), 1);
    chk("R2 boot len", int'(len), OKL);
    chk("R8 boot not counted", int'(rj), 0);
    @(negedge clk);
    chk("R3 x low in task", int'(x), 0);
    chk("R1 y low in task", int'(y), 0);
    chk("R3 busy in task", int'(busy), 1);

    // R4/R8 three steady successes
    success_step(OKL, 0, "R4 s1");
    success_step(OKL, 0, "R4 s2");
    success_step(OKL, 1, "R4 s3");

    // R5/R6 peer1 absent: four misses
    p1 = 1'b0;
    prev = OKL;
    for (int k = 1; k <= 4; k++) begin
      wait_start("R5");
      chk("R5 gap fail", gap, prev + HS + SF);
      chk("R5 ok", int'(ok), 0);
      chk("R5 len", int'(len), FL);
      chk("R8 rejoin cleared", int'(rj), 0);
      chk("R6 fault1", int'(flt[1]), (k >= 4) ? 1 : 0);
      chk("R6 fault0 seen peer", int'(flt[0]), 0);
      prev = FL;
    end

    // R7 retry after failure
    p1 = 1'b1;
    wait_start("R7");
    chk("R7 gap retry", gap, FL + 1 + GD);
    chk("R7 ok", int'(ok), 1);
    chk("R6 fault cleared", int'(flt[1]), 0);

    // R4/R5 boundary sweep of peer arrival inside the window
    for (int d = 0; d <= int'(HS); d++) begin
      p1 = 1'b0;
      for (int i = 0; i < 200 && !x; i++) @(negedge clk);
      repeat (d) @(negedge clk);
      p1 = 1'b1;
      wait_start("R4 sweep");
      chk((d <= int'(HS) - 3) ? "R4 late success ok" : "R5 late miss ok",
          int'(ok), (d <= int'(HS) - 3) ? 1 : 0);
      chk("R4 sweep len", int'(len), (d <= int'(HS) - 3) ? OKL : FL);
    end

    // R6 both peers absent: both faults on the fourth miss
    wait_start("R7 recover");
    p0 = 1'b0; p1 = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      wait_start("R6 both");
      chk("R6 both faults", int'(flt), (k >= 4) ? 3 : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule